// File: doc/BRIEF.md
# Boost Stage Open-Loop State Estimator

This block keeps a running fixed-point estimate of the two energy-storage states of a boost power stage: the inductor current and the output capacitor voltage. A fixed step of `STEP_CYCLES` clock cycles (100 cycles, 500 ns at a 200 MHz clock) sets the update rate. On each step the block samples the input voltage, the load current, the two measured states and the low-side switch gate. It then advances its estimate by one forward-Euler step of the continuous boost model. The switch position picks the dynamics: with the switch closed the inductor is cut off from the capacitor, and with it open the inductor current charges the capacitor.

The estimator runs open loop, with no correction from the measurements. Circuit losses make a fault-free error die out. The measured values minus the estimate form a residual, which is scaled by two configurable reciprocal constants (one for the voltage base, one for the current base) and issued with a one-cycle valid pulse. A fault monitor downstream treats a residual that stays non-zero as a fault symptom. Five signed Q2.14 coefficients are written through a small select/value port. A load strobe can preset the estimate.

Top module: `boost_state_estimator`

## Requirements
- R1: While rst_n is low, and after it rises, both estimates and both residuals are 0 and res_valid is low. The coefficients come out of reset at their defaults: dt/L, R·dt/L and dt/C at 0, both normalisers at 1.0 (16384).
- R2: res_valid is high for exactly one cycle per step. The first pulse follows the (STEP_CYCLES+2)-th rising edge after rst_n rises, two of those edges being reset synchronisation. Later pulses are exactly STEP_CYCLES cycles apart.
- R3: With sw_closed=0, a step sets il_est to sat(il + floor((a·vin − b·il − a·vc) / 2^14)). Here a is dt/L, b is R·dt/L, and il, vc are the estimates before the step.
- R4: With sw_closed=1, a step sets il_est to sat(il + floor((a·vin − b·il) / 2^14)) and vc_est to sat(vc + floor(−c·iload / 2^14)), where c is dt/C. With zero load current the voltage estimate holds.
- R5: With sw_closed=0, a step sets vc_est to sat(vc + floor(c·(il − iload) / 2^14)).
- R6: In each step, il_res = sat(floor((il_meas − il)·ki / 2^14)) and vc_res = sat(floor((vc_meas − vc)·kv / 2^14)). These use the estimates before the update, and both appear together with res_valid.
- R7: Estimates and residuals saturate to the signed 16-bit range [−32768, 32767] and never wrap.
- R8: A high ld_stb makes il_est = ld_il and vc_est = ld_vc one cycle later. The load wins over a step update in the same cycle, but that step still issues its residual against the estimate held before the load.
- R9: cfg_we writes cfg_val into the coefficient picked by cfg_sel: 0 dt/L, 1 R·dt/L, 2 dt/C, 3 voltage normaliser kv, 4 current normaliser ki. Select codes 5 to 7 change nothing. A write takes effect from the next step.
- R10: Between steps, and with no load strobe, both estimates hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_closed | input | 1 | Low-side switch gate, 1 = closed |
| vin_smp | input | 16 | Sampled input voltage, signed |
| iload_smp | input | 16 | Sampled load current, signed |
| il_meas | input | 16 | Measured inductor current, signed |
| vc_meas | input | 16 | Measured capacitor voltage, signed |
| ld_stb | input | 1 | Estimate preload strobe |
| ld_il | input | 16 | Preload value for the current estimate |
| ld_vc | input | 16 | Preload value for the voltage estimate |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 3 | Coefficient select |
| cfg_val | input | 16 | Coefficient value, signed Q2.14 |
| il_est | output | 16 | Inductor current estimate |
| vc_est | output | 16 | Capacitor voltage estimate |
| il_res | output | 16 | Normalised current residual |
| vc_res | output | 16 | Normalised voltage residual |
| res_valid | output | 1 | One-cycle residual strobe |

## Verification
The estimates and residuals of a step are all registered on the same clock edge, the one where the internal step tick is high. They therefore show up together in the cycle where res_valid is high. A load or a coefficient write shows its effect one edge later, a coefficient write only in the following step. The bench changes inputs only at the falling edge just after a res_valid cycle, keeps them steady until the next tick, and checks every result at the falling edge where res_valid is seen, against a model advanced once per step. It times the preload collision case by counting STEP_CYCLES−1 falling edges from a pulse, so the strobe lands on the tick edge.

// File: rtl/boost_est_pkg.sv
package boost_est_pkg;
  localparam int unsigned SMP_W     = 16;
  localparam int unsigned COEF_W    = 16;
  localparam int unsigned COEF_FRAC = 14;
  localparam int unsigned STEP_CYC  = 100;
  localparam int unsigned N_COEF    = 5;
  localparam int unsigned SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DT_L  = 3'd0,
    SEL_RDT_L = 3'd1,
    SEL_DT_C  = 3'd2,
    SEL_KV    = 3'd3,
    SEL_KI    = 3'd4
  } coef_sel_e;
endpackage

// File: rtl/est_sat.sv
module est_sat #(
  parameter int unsigned IW = 34,
  parameter int unsigned OW = 16
) (
  input  logic signed [IW-1:0] in_v,
  output logic signed [OW-1:0] out_v
);
  localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    if (in_v > MAXV)      out_v = MAXV[OW-1:0];
    else if (in_v < MINV) out_v = MINV[OW-1:0];
    else                  out_v = in_v[OW-1:0];
  end
endmodule

// File: rtl/est_coef_regs.sv
module est_coef_regs #(
  parameter int unsigned CW    = 16,
  parameter int unsigned NC    = 5,
  parameter int unsigned SELW  = 3,
  parameter logic [NC*CW-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [CW-1:0]   cfg_val,
  output logic [NC*CW-1:0] coef_o
);
  for (genvar g = 0; g < NC; g++) begin : g_coef
    logic [CW-1:0] q, nxt;
    logic          hit;
    assign hit = cfg_we && (cfg_sel == SELW'(g));

    always_comb begin
      nxt = q;
      if (hit) nxt = cfg_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL[g*CW +: CW];
      else if (hit) q <= nxt;
    end

    assign coef_o[g*CW +: CW] = q;
  end

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel >= SELW'(NC))) |=> $stable(coef_o));
endmodule

// File: rtl/est_tick.sv
module est_tick #(
  parameter int unsigned STEP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNTW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(STEP_CYCLES - 1);

  logic [CNTW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/est_state.sv
module est_state #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned CF = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 sw_closed,
  input  logic signed [DW-1:0] vin,
  input  logic signed [DW-1:0] iload,
  input  logic                 ld_stb,
  input  logic signed [DW-1:0] ld_il,
  input  logic signed [DW-1:0] ld_vc,
  input  logic signed [CW-1:0] k_dtl,
  input  logic signed [CW-1:0] k_rdtl,
  input  logic signed [CW-1:0] k_dtc,
  output logic signed [DW-1:0] il_q,
  output logic signed [DW-1:0] vc_q
);
  localparam int unsigned SW = DW + CW + 3;
  localparam int unsigned NW = SW + 1;

  logic signed [SW-1:0]   m_vin, m_ril, m_vc, m_chg, sum_il, sum_vc;
  logic signed [DW:0]     chg_cur;
  logic signed [NW-1:0]   raw_il, raw_vc;
  logic signed [DW-1:0]   sat_il, sat_vc, il_d, vc_d;

  // switch open: inductor current and capacitor voltage couple
  always_comb begin
    chg_cur = sw_closed ? -(DW+1)'(iload) : (DW+1)'(il_q) - (DW+1)'(iload);
    m_vin   = SW'(k_dtl)  * SW'(vin);
    m_ril   = SW'(k_rdtl) * SW'(il_q);
    m_vc    = sw_closed ? '0 : SW'(k_dtl) * SW'(vc_q);
    m_chg   = SW'(k_dtc)  * SW'(chg_cur);
    sum_il  = m_vin - m_ril - m_vc;
    sum_vc  = m_chg;
    raw_il  = NW'(il_q) + NW'(sum_il >>> CF);
    raw_vc  = NW'(vc_q) + NW'(sum_vc >>> CF);
  end

  est_sat #(.IW(NW), .OW(DW)) u_sat_il (.in_v(raw_il), .out_v(sat_il));
  est_sat #(.IW(NW), .OW(DW)) u_sat_vc (.in_v(raw_vc), .out_v(sat_vc));

  always_comb begin
    il_d = il_q;
    vc_d = vc_q;
    if (ld_stb) begin
      il_d = ld_il;
      vc_d = ld_vc;
    end else if (tick) begin
      il_d = sat_il;
      vc_d = sat_vc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q <= '0;
      vc_q <= '0;
    end else if (ld_stb || tick) begin
      il_q <= il_d;
      vc_q <= vc_d;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_stb) |=> ($stable(il_q) && $stable(vc_q)));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> ((il_q == $past(ld_il)) && (vc_q == $past(ld_vc))));

  // R4
  closed_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sw_closed && !ld_stb && (iload == '0)) |=> $stable(vc_q));
endmodule

// File: rtl/est_resid.sv
module est_resid #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned CF = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [DW-1:0] meas_il,
  input  logic signed [DW-1:0] meas_vc,
  input  logic signed [DW-1:0] est_il,
  input  logic signed [DW-1:0] est_vc,
  input  logic signed [CW-1:0] k_cur,
  input  logic signed [CW-1:0] k_volt,
  output logic signed [DW-1:0] res_il,
  output logic signed [DW-1:0] res_vc,
  output logic                 res_valid
);
  localparam int unsigned NCH = 2;
  localparam int unsigned RW  = DW + 1 + CW;

  logic signed [DW-1:0] meas_a [NCH];
  logic signed [DW-1:0] est_a  [NCH];
  logic signed [CW-1:0] k_a    [NCH];
  logic signed [DW-1:0] res_a  [NCH];

  assign meas_a[0] = meas_il;  assign meas_a[1] = meas_vc;
  assign est_a[0]  = est_il;   assign est_a[1]  = est_vc;
  assign k_a[0]    = k_cur;    assign k_a[1]    = k_volt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW:0]   diff;
    logic signed [RW-1:0] prod;
    logic signed [RW-1:0] scaled;
    logic signed [DW-1:0] sat_v, res_d, res_q;

    always_comb begin
      diff   = (DW+1)'(meas_a[c]) - (DW+1)'(est_a[c]);
      prod   = RW'(diff) * RW'(k_a[c]);
      scaled = prod >>> CF;
    end

    est_sat #(.IW(RW), .OW(DW)) u_sat (.in_v(scaled), .out_v(sat_v));

    always_comb begin
      res_d = res_q;
      if (tick) res_d = sat_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    res_q <= '0;
      else if (tick) res_q <= res_d;
    end

    assign res_a[c] = res_q;

    // R6
    zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (meas_a[c] == est_a[c])) |=> (res_q == '0));
  end

  assign res_il = res_a[0];
  assign res_vc = res_a[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= tick;
  end
endmodule

// File: rtl/boost_state_estimator.sv
module boost_state_estimator
  import boost_est_pkg::*;
#(
  parameter int unsigned DW          = SMP_W,
  parameter int unsigned CW          = COEF_W,
  parameter int unsigned CF          = COEF_FRAC,
  parameter int unsigned STEP_CYCLES = STEP_CYC,
  parameter logic [CW-1:0] RST_DTL   = '0,
  parameter logic [CW-1:0] RST_RDTL  = '0,
  parameter logic [CW-1:0] RST_DTC   = '0,
  parameter logic [CW-1:0] RST_KV    = CW'(1 << CF),
  parameter logic [CW-1:0] RST_KI    = CW'(1 << CF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sw_closed,
  input  logic signed [DW-1:0]   vin_smp,
  input  logic signed [DW-1:0]   iload_smp,
  input  logic signed [DW-1:0]   il_meas,
  input  logic signed [DW-1:0]   vc_meas,
  input  logic                   ld_stb,
  input  logic signed [DW-1:0]   ld_il,
  input  logic signed [DW-1:0]   ld_vc,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [CW-1:0]          cfg_val,
  output logic signed [DW-1:0]   il_est,
  output logic signed [DW-1:0]   vc_est,
  output logic signed [DW-1:0]   il_res,
  output logic signed [DW-1:0]   vc_res,
  output logic                   res_valid
);
  localparam logic [N_COEF*CW-1:0] RST_ALL = {RST_KI, RST_KV, RST_DTC, RST_RDTL, RST_DTL};
  localparam int unsigned GW = $clog2(STEP_CYCLES + 1) + 1;

  logic               rs1_q, rs2_q, rst_i_n;
  logic [N_COEF*CW-1:0] coef;
  logic               tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  est_coef_regs #(.CW(CW), .NC(N_COEF), .SELW(SEL_W), .RST_VAL(RST_ALL)) u_coef (
    .clk(clk), .rst_n(rst_i_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .coef_o(coef));

  est_tick #(.STEP_CYCLES(STEP_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .tick(tick));

  est_state #(.DW(DW), .CW(CW), .CF(CF)) u_state (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .sw_closed(sw_closed),
    .vin(vin_smp), .iload(iload_smp), .ld_stb(ld_stb), .ld_il(ld_il), .ld_vc(ld_vc),
    .k_dtl(coef[int'(SEL_DT_L)*CW +: CW]),
    .k_rdtl(coef[int'(SEL_RDT_L)*CW +: CW]),
    .k_dtc(coef[int'(SEL_DT_C)*CW +: CW]),
    .il_q(il_est), .vc_q(vc_est));

  est_resid #(.DW(DW), .CW(CW), .CF(CF)) u_resid (
    .clk(clk), .rst_n(rst_i_n), .tick(tick),
    .meas_il(il_meas), .meas_vc(vc_meas), .est_il(il_est), .est_vc(vc_est),
    .k_cur(coef[int'(SEL_KI)*CW +: CW]), .k_volt(coef[int'(SEL_KV)*CW +: CW]),
    .res_il(il_res), .res_vc(vc_res), .res_valid(res_valid));

  // step-spacing checker
  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (res_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GW{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2
  step_gap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_valid && seen_q) |-> (gap_q == GW'(STEP_CYCLES - 1)));
endmodule

// File: tb/boost_state_estimator_test.sv
`timescale 1ns/1ps
module boost_state_estimator_test;
  localparam int STEP = 100;
  localparam int CF   = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_closed;
  logic signed [15:0] vin_smp, iload_smp, il_meas, vc_meas, ld_il, ld_vc;
  logic ld_stb, cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_val;
  logic signed [15:0] il_est, vc_est, il_res, vc_res;
  logic res_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  longint m_il, m_vc, m_a, m_b, m_c, m_kv, m_ki;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  boost_state_estimator uut (
    .clk(clk), .rst_n(rst_n), .sw_closed(sw_closed), .vin_smp(vin_smp),
    .iload_smp(iload_smp), .il_meas(il_meas), .vc_meas(vc_meas), .ld_stb(ld_stb),
    .ld_il(ld_il), .ld_vc(ld_vc), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .il_est(il_est), .vc_est(vc_est), .il_res(il_res), .vc_res(vc_res),
    .res_valid(res_valid));

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // wait (at falling edges) until res_valid is seen
  task automatic wait_valid(string tag);
    int n = 0;
    @(negedge clk);
    while (!res_valid && n < 3 * STEP) begin
      @(negedge clk);
      n++;
    end
    if (!res_valid) chk({tag, " no res_valid"}, 0, 1);
  endtask

  // expected results of one step from the spec; returns residuals, advances model
  task automatic model_step(output longint e_ri, output longint e_rv);
    longint dil, dvc, nil, nvc;
    longint s = sw_closed;
    e_ri = sat16(((longint'(il_meas) - m_il) * m_ki) >>> CF);
    e_rv = sat16(((longint'(vc_meas) - m_vc) * m_kv) >>> CF);
    dil = m_a * vin_smp - m_b * m_il - (s != 0 ? 0 : m_a * m_vc);
    dvc = m_c * ((s != 0 ? 0 : m_il) - longint'(iload_smp));
    nil = sat16(m_il + (dil >>> CF));
    nvc = sat16(m_vc + (dvc >>> CF));
    m_il = nil;
    m_vc = nvc;
  endtask

  task automatic step_chk(string tag);
    longint e_ri, e_rv;
    wait_valid(tag);
    model_step(e_ri, e_rv);
    chk({tag, " il_res"}, il_res, e_ri);
    chk({tag, " vc_res"}, vc_res, e_rv);
    chk({tag, " il_est"}, il_est, m_il);
    chk({tag, " vc_est"}, vc_est, m_vc);
  endtask

  task automatic cfg_write(logic [2:0] sel, logic [15:0] val);
    cfg_sel = sel; cfg_val = val; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_a  = longint'($signed(val));
      3'd1: m_b  = longint'($signed(val));
      3'd2: m_c  = longint'($signed(val));
      3'd3: m_kv = longint'($signed(val));
      3'd4: m_ki = longint'($signed(val));
      default: ;
    endcase
  endtask

  task automatic t_reset;
    int n = 0;
    chk("R1 il_est in reset", il_est, 0);
    chk("R1 vc_res in reset", vc_res, 0);
    chk("R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); n++;
    while (!res_valid && n < 3 * STEP) begin
      @(negedge clk); n++;
    end
    chk("R2 first pulse latency", n, STEP + 2);
    // defaults: zero dynamics, unity normalisers
    begin
      longint e_ri, e_rv;
      model_step(e_ri, e_rv);
      chk("R1 default il_res", il_res, e_ri);
      chk("R1 default vc_res", vc_res, e_rv);
      chk("R1 default il_est", il_est, 0);
    end
    @(negedge clk);
    chk("R2 single-cycle pulse", res_valid, 0);
    n = 1;
    while (!res_valid && n < 3 * STEP) begin
      @(negedge clk); n++;
    end
    chk("R2 pulse spacing", n, STEP);
    begin
      longint e_ri, e_rv;
      model_step(e_ri, e_rv);
    end
  endtask

  task automatic t_open;
    cfg_write(3'd0, 16'sd328);
    cfg_write(3'd1, 16'sd33);
    cfg_write(3'd2, 16'sd200);
    cfg_write(3'd3, 16'sd7000);
    cfg_write(3'd4, 16'sd12000);
    sw_closed = 1'b0; vin_smp = 1900; iload_smp = 50; il_meas = 300; vc_meas = 3800;
    for (int k = 0; k < 8; k++) step_chk("R3 R5 R6 open");
    for (int k = 0; k < 6; k++) begin
      sw_closed = k[0];
      il_meas = 16'(200 + 40 * k);
      step_chk("R3 R4 R6 alternating");
    end
  endtask

  task automatic t_closed;
    sw_closed = 1'b1; iload_smp = 120; vin_smp = 2500;
    for (int k = 0; k < 3; k++) step_chk("R4 closed");
    iload_smp = 0;
    begin
      longint vprev = vc_est;
      step_chk("R4 closed no load");
      chk("R4 vc holds with zero load", vc_est, vprev);
    end
  endtask

  task automatic t_hold;
    longint hi = il_est, hv = vc_est;
    for (int k = 0; k < 3; k++) begin
      repeat (20) @(negedge clk);
      chk("R10 il_est holds", il_est, hi);
      chk("R10 vc_est holds", vc_est, hv);
    end
  endtask

  task automatic t_load;
    longint e_ri, e_rv;
    step_chk("R8 before load");
    @(negedge clk);
    ld_il = 1234; ld_vc = -567; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    chk("R8 il load", il_est, 1234);
    chk("R8 vc load", vc_est, -567);
    m_il = 1234; m_vc = -567;
    step_chk("R8 after load");
    // strobe on the tick edge
    repeat (STEP - 1) @(negedge clk);
    ld_il = -900; ld_vc = 4321; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    chk("R8 collision res_valid", res_valid, 1);
    model_step(e_ri, e_rv);
    chk("R8 collision il_res uses old estimate", il_res, e_ri);
    chk("R8 collision vc_res uses old estimate", vc_res, e_rv);
    chk("R8 collision il load wins", il_est, -900);
    chk("R8 collision vc load wins", vc_est, 4321);
    m_il = -900; m_vc = 4321;
  endtask

  task automatic t_cfg;
    cfg_write(3'd5, 16'h7fff);
    cfg_write(3'd6, 16'h4000);
    cfg_write(3'd7, 16'h8001);
    sw_closed = 1'b0;
    step_chk("R9 unused selects ignored");
    cfg_write(3'd2, 16'sd900);
    step_chk("R9 new dt/C used");
  endtask

  task automatic t_sat;
    cfg_write(3'd0, 16'sd16384);
    cfg_write(3'd1, 16'sd0);
    cfg_write(3'd2, 16'sd16384);
    cfg_write(3'd4, 16'sd16384);
    sw_closed = 1'b1; vin_smp = 30000; iload_smp = -30000;
    il_meas = -32768; vc_meas = 0;
    for (int k = 0; k < 3; k++) step_chk("R7 saturating");
    chk("R7 il_est clamps high", il_est, 32767);
    chk("R7 vc_est clamps high", vc_est, 32767);
    step_chk("R7 residual");
    chk("R7 il_res clamps low", il_res, -32768);
  endtask

  initial begin
    rst_n = 1'b0; sw_closed = 1'b0; vin_smp = 0; iload_smp = 0;
    il_meas = 100; vc_meas = -200; ld_stb = 1'b0; ld_il = 0; ld_vc = 0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_val = '0;
    m_il = 0; m_vc = 0; m_a = 0; m_b = 0; m_c = 0; m_kv = 16384; m_ki = 16384;
    repeat (4) @(negedge clk);
    t_reset;
    t_open;
    t_closed;
    t_hold;
    t_load;
    t_cfg;
    t_sat;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule